// File: doc/BRIEF.md
# 8-bit Register ALU Execute Stage

This block is the execute stage of a small single-issue 8-bit register machine. Each cycle in which `instr_valid` is high it takes one 16-bit instruction word and decodes it in one of two fixed layouts. One layout names two registers. The other names a destination in the upper half of the register file and carries an 8-bit constant. The stage reads its 32-entry, 8-bit register file and runs one operation from a small set: add, subtract, compare, move, load-constant and bitwise logic. It writes the result back, updates a four-bit status register and advances the program counter by one. The whole instruction completes in that clock edge.

Every subtraction and every addition passes through one shared 9-bit adder. For a subtraction the second operand is inverted and a carry-in is chosen per instruction. The carry flag is then inverted so that it reports a borrow. Fetch, memory access, branches and interrupts belong to other blocks. A combinational peek port lets the surrounding logic read any register.

Top module: `alu8_exec_unit`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the PC, the status register and all 32 registers become zero.
- R2: In a register-register word, the opcode is in bits 15:10. The destination index is {bit 8, bits 7:4} and the source index is {bit 9, bits 3:0}.
- R3: In a register-constant word, the opcode is in bits 15:12 and the constant is {bits 11:8, bits 3:0}. The destination index is 16 plus bits 7:4.
- R4: Register-register opcode 000011 computes d = d + s. Opcode 000111 computes d = d + s + C. C is the unsigned carry out of bit 7.
- R5: Opcode 000110 computes d = d − s and constant opcode 0101 computes d = d − K. C is set when the subtrahend is larger than d, read as unsigned numbers.
- R6: Opcode 000010 computes d = d − s − C and constant opcode 0100 computes d = d − K − C. C is set when the subtrahend plus the old C is larger than d.
- R7: Opcodes 000101 and 000001 set the flags exactly as 000110 and 000010 do, but write no register.
- R8: Opcodes 001000 (and), 001010 (or) and 001001 (xor), and constant opcodes 0111 (and) and 0110 (or), write the bitwise result, clear V, set Z and N from the result and leave C unchanged.
- R9: Opcode 001011 copies register s into d. Constant opcode 1110 loads K into d. Neither changes any flag.
- R10: The status bits are C at bit 0, Z at bit 1 (result is zero), N at bit 2 (result bit 7) and V at bit 3 (two's-complement overflow) of `status`.
- R11: Every valid word, including all-zero and unlisted opcodes, advances the PC by exactly one. Unlisted opcodes change nothing else. Cycles without `instr_valid` change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr_word | input | 16 | Instruction to execute |
| peek_idx | input | 5 | Register index for the peek port |
| peek_data | output | 8 | Current contents of register `peek_idx` |
| pc | output | 16 | Program counter |
| status | output | 4 | Status flags {V,N,Z,C} |

## Verification
A wrong decode or a wrong operand split shows up at the peek port one edge after the instruction. It appears either in the wrong destination or as a stray write to another register. The bench therefore sweeps the whole file from time to time. A wrong carry-in or a wrong borrow polarity appears in `status` bit 0 right after the instruction and spreads into the next chained subtraction. PC slips appear on the first cycle they happen, because the PC is compared after every step and after idle cycles.

// File: rtl/alu8_pkg.sv
// Package: shared widths, opcode values, flag positions and decode types
// for the 8-bit execute stage. Assumes a 16-bit instruction word.
package alu8_pkg;
    localparam int DATA_W  = 8;
    localparam int REG_N   = 32;
    localparam int REG_AW  = $clog2(REG_N);
    localparam int INSTR_W = 16;
    localparam int FLAG_W  = 4;

    localparam int FLAG_C = 0;
    localparam int FLAG_Z = 1;
    localparam int FLAG_N = 2;
    localparam int FLAG_V = 3;

    // register-register opcodes (bits 15:10)
    localparam logic [5:0] RR_ADD = 6'b000011;
    localparam logic [5:0] RR_ADC = 6'b000111;
    localparam logic [5:0] RR_SUB = 6'b000110;
    localparam logic [5:0] RR_SBC = 6'b000010;
    localparam logic [5:0] RR_CMP = 6'b000101;
    localparam logic [5:0] RR_CMC = 6'b000001;
    localparam logic [5:0] RR_AND = 6'b001000;
    localparam logic [5:0] RR_XOR = 6'b001001;
    localparam logic [5:0] RR_OR  = 6'b001010;
    localparam logic [5:0] RR_MOV = 6'b001011;

    // register-constant opcodes (bits 15:12)
    localparam logic [3:0] RK_LD  = 4'b1110;
    localparam logic [3:0] RK_SUB = 4'b0101;
    localparam logic [3:0] RK_SBC = 4'b0100;
    localparam logic [3:0] RK_AND = 4'b0111;
    localparam logic [3:0] RK_OR  = 4'b0110;

    typedef enum logic [2:0] {
        FN_NONE, FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR, FN_PASS
    } alu_fn_e;

    typedef enum logic [1:0] {
        CIN_ZERO, CIN_ONE, CIN_CFLAG, CIN_NCFLAG
    } cin_sel_e;

    typedef struct packed {
        alu_fn_e             fn;
        cin_sel_e            cin_sel;
        logic [REG_AW-1:0]   rd_idx;
        logic [REG_AW-1:0]   rs_idx;
        logic                use_k;
        logic [DATA_W-1:0]   k_val;
        logic                wr_en;
        logic                flags_en;
    } dec_t;
endpackage

// File: rtl/alu8_decode.sv
// Module: alu8_decode
// Splits a 16-bit word into operation, register indices and constant.
// Assumes the constant opcodes (top nibble) never collide with the
// register-register opcodes (top six bits start 00). Purely combinational.
module alu8_decode
    import alu8_pkg::*;
(
    input  logic [INSTR_W-1:0] word,
    output dec_t               dec
);
    // Decode one word; unlisted encodings fall back to a do-nothing entry.
    always_comb begin
        dec          = '0;
        dec.fn       = FN_NONE;
        dec.cin_sel  = CIN_ZERO;
        dec.rd_idx   = {word[8], word[7:4]};
        dec.rs_idx   = {word[9], word[3:0]};
        dec.k_val    = {word[11:8], word[3:0]};
        dec.use_k    = 1'b0;
        dec.wr_en    = 1'b0;
        dec.flags_en = 1'b0;
        unique case (word[15:12])
            RK_LD, RK_SUB, RK_SBC, RK_AND, RK_OR: begin
                dec.rd_idx = {1'b1, word[7:4]};
                dec.use_k  = 1'b1;
                dec.wr_en  = 1'b1;
                unique case (word[15:12])
                    RK_LD:  dec.fn = FN_PASS;
                    RK_SUB: begin dec.fn = FN_SUB; dec.cin_sel = CIN_ONE;    dec.flags_en = 1'b1; end
                    RK_SBC: begin dec.fn = FN_SUB; dec.cin_sel = CIN_NCFLAG; dec.flags_en = 1'b1; end
                    RK_AND: begin dec.fn = FN_AND; dec.flags_en = 1'b1; end
                    default: begin dec.fn = FN_OR; dec.flags_en = 1'b1; end
                endcase
            end
            default: begin
                unique case (word[15:10])
                    RR_ADD: begin dec.fn = FN_ADD; dec.wr_en = 1'b1; dec.flags_en = 1'b1; end
                    RR_ADC: begin dec.fn = FN_ADD; dec.cin_sel = CIN_CFLAG;  dec.wr_en = 1'b1; dec.flags_en = 1'b1; end
                    RR_SUB: begin dec.fn = FN_SUB; dec.cin_sel = CIN_ONE;    dec.wr_en = 1'b1; dec.flags_en = 1'b1; end
                    RR_SBC: begin dec.fn = FN_SUB; dec.cin_sel = CIN_NCFLAG; dec.wr_en = 1'b1; dec.flags_en = 1'b1; end
                    RR_CMP: begin dec.fn = FN_SUB; dec.cin_sel = CIN_ONE;    dec.flags_en = 1'b1; end
                    RR_CMC: begin dec.fn = FN_SUB; dec.cin_sel = CIN_NCFLAG; dec.flags_en = 1'b1; end
                    RR_AND: begin dec.fn = FN_AND; dec.wr_en = 1'b1; dec.flags_en = 1'b1; end
                    RR_XOR: begin dec.fn = FN_XOR; dec.wr_en = 1'b1; dec.flags_en = 1'b1; end
                    RR_OR:  begin dec.fn = FN_OR;  dec.wr_en = 1'b1; dec.flags_en = 1'b1; end
                    RR_MOV: begin dec.fn = FN_PASS; dec.wr_en = 1'b1; end
                    default: dec.fn = FN_NONE;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/alu8_alu.sv
// Module: alu8_alu
// One shared adder serves add and subtract; subtract inverts the second
// operand and inverts the carry out so C reads as a borrow. Logic ops
// clear V and pass C through. Combinational; the caller decides whether
// the flags are kept.
module alu8_alu
    import alu8_pkg::*;
(
    input  alu_fn_e            fn,
    input  cin_sel_e           cin_sel,
    input  logic [DATA_W-1:0]  op_a,
    input  logic [DATA_W-1:0]  op_b,
    input  logic               c_flag,
    output logic [DATA_W-1:0]  result,
    output logic [FLAG_W-1:0]  flags_new
);
    logic              is_sub;
    logic              cin;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   sum;
    logic              c_out;
    logic              v_out;

    // Pick the adder carry-in from the instruction's selection.
    always_comb begin
        unique case (cin_sel)
            CIN_ZERO:   cin = 1'b0;
            CIN_ONE:    cin = 1'b1;
            CIN_CFLAG:  cin = c_flag;
            default:    cin = ~c_flag;
        endcase
    end

    // Shared adder with conditional operand inversion.
    always_comb begin
        is_sub = (fn == FN_SUB);
        b_eff  = is_sub ? ~op_b : op_b;
        sum    = {1'b0, op_a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
    end

    // Select the result and the carry and overflow flags per function.
    always_comb begin
        result = op_b;
        c_out  = c_flag;
        v_out  = 1'b0;
        unique case (fn)
            FN_ADD, FN_SUB: begin
                result = sum[DATA_W-1:0];
                c_out  = sum[DATA_W] ^ is_sub;
                v_out  = (op_a[DATA_W-1] == b_eff[DATA_W-1]) &&
                         (sum[DATA_W-1] != op_a[DATA_W-1]);
            end
            FN_AND:  result = op_a & op_b;
            FN_OR:   result = op_a | op_b;
            FN_XOR:  result = op_a ^ op_b;
            default: result = op_b;
        endcase
    end

    // Pack the new flag word in its fixed bit order.
    always_comb begin
        flags_new         = '0;
        flags_new[FLAG_C] = c_out;
        flags_new[FLAG_Z] = (result == '0);
        flags_new[FLAG_N] = result[DATA_W-1];
        flags_new[FLAG_V] = v_out;
    end
endmodule

// File: rtl/alu8_regfile.sv
// Module: alu8_regfile
// 32 x 8 register file: one write port, two operand read ports and one
// peek port, all reads combinational. Synchronous active-low reset
// clears every entry.
module alu8_regfile
    import alu8_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [REG_AW-1:0]  wr_idx,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [REG_AW-1:0]  rd_a_idx,
    output logic [DATA_W-1:0]  rd_a_data,
    input  logic [REG_AW-1:0]  rd_b_idx,
    output logic [DATA_W-1:0]  rd_b_data,
    input  logic [REG_AW-1:0]  peek_idx,
    output logic [DATA_W-1:0]  peek_data
);
    logic [REG_N-1:0][DATA_W-1:0] mem;

    for (genvar gi = 0; gi < REG_N; gi++) begin : g_entry
        // Clear on reset, otherwise take the write aimed at this entry.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[gi] <= '0;
            else if (wr_en && (wr_idx == REG_AW'(gi)))
                mem[gi] <= wr_data;
        end
    end

    // Combinational read ports.
    assign rd_a_data = mem[rd_a_idx];
    assign rd_b_data = mem[rd_b_idx];
    assign peek_data = mem[peek_idx];

    // R7
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mem));
    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/alu8_exec_unit.sv
// Module: alu8_exec_unit (top)
// Executes one instruction per valid cycle: decode, operand read, ALU,
// write-back, flag update and PC increment all on one edge. Assumes the
// fetch side supplies at most one word per cycle; no stall is needed.
module alu8_exec_unit
    import alu8_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [15:0]        instr_word,
    input  logic [4:0]         peek_idx,
    output logic [7:0]         peek_data,
    output logic [PC_W-1:0]    pc,
    output logic [3:0]         status
);
    dec_t              dec;
    logic [DATA_W-1:0] rd_val;
    logic [DATA_W-1:0] rs_val;
    logic [DATA_W-1:0] op_b;
    logic [DATA_W-1:0] alu_res;
    logic [FLAG_W-1:0] flags_new;
    logic [FLAG_W-1:0] flags_q;
    logic [PC_W-1:0]   pc_q;
    logic              is_logic;

    alu8_decode u_dec (
        .word (instr_word),
        .dec  (dec)
    );

    alu8_regfile u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (instr_valid && dec.wr_en),
        .wr_idx    (dec.rd_idx),
        .wr_data   (alu_res),
        .rd_a_idx  (dec.rd_idx),
        .rd_a_data (rd_val),
        .rd_b_idx  (dec.rs_idx),
        .rd_b_data (rs_val),
        .peek_idx  (peek_idx),
        .peek_data (peek_data)
    );

    // Second operand is the constant or the source register.
    assign op_b = dec.use_k ? dec.k_val : rs_val;

    alu8_alu u_alu (
        .fn        (dec.fn),
        .cin_sel   (dec.cin_sel),
        .op_a      (rd_val),
        .op_b      (op_b),
        .c_flag    (flags_q[FLAG_C]),
        .result    (alu_res),
        .flags_new (flags_new)
    );

    // Status register: loaded only by flag-setting instructions.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else if (instr_valid && dec.flags_en)
            flags_q <= flags_new;
    end

    // Program counter: one step per accepted instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= '0;
        else if (instr_valid)
            pc_q <= pc_q + PC_W'(1);
    end

    assign pc     = pc_q;
    assign status = flags_q;
    assign is_logic = (dec.fn == FN_AND) || (dec.fn == FN_OR) || (dec.fn == FN_XOR);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (pc_q == '0) && (flags_q == '0));
    // R11
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |=> pc_q == $past(pc_q) + PC_W'(1));
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> $stable(pc_q) && $stable(flags_q));
    // R8
    logic_v_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && is_logic |=> !flags_q[FLAG_V]);
    // R8
    logic_c_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && is_logic |=> flags_q[FLAG_C] == $past(flags_q[FLAG_C]));
    // R9
    move_flags_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && (dec.fn == FN_PASS) |=> $stable(flags_q));
endmodule

// File: tb/alu8_exec_unit_tb_top.sv
module alu8_exec_unit_tb_top;
    localparam int CLK_PERIOD = 100;
    localparam int WDOG_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = '0;
    logic [4:0]  peek_idx = '0;
    logic [7:0]  peek_data;
    logic [15:0] pc;
    logic [3:0]  status;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int cycles = 0;

    logic [7:0]  m_reg [32];
    logic [3:0]  m_flags;
    logic [15:0] m_pc;

    alu8_exec_unit dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
        .instr_word(instr_word), .peek_idx(peek_idx), .peek_data(peek_data),
        .pc(pc), .status(status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WDOG_LIMIT && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog act=%0d exp<%0d", cycles, WDOG_LIMIT);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] enc_rr(input logic [5:0] op, input int d, input int s);
        logic [4:0] dd = 5'(d);
        logic [4:0] ss = 5'(s);
        return {op, ss[4], dd[4], dd[3:0], ss[3:0]};
    endfunction

    function automatic logic [15:0] enc_rk(input logic [3:0] op, input int d, input logic [7:0] k);
        logic [4:0] dd = 5'(d);
        return {op, k[7:4], dd[3:0], k[3:0]};
    endfunction

    // Reference model from the requirements; returns tag and written index.
    task automatic model_exec(input logic [15:0] w, output string tag, output int dest);
        int d, s, a, b, bin, r, sa, sb, sr;
        bit imm, upd, wr, kind_sub, kind_add, kind_log;
        logic [7:0] res;
        logic [3:0] nf;
        imm = 0; upd = 0; wr = 0; kind_sub = 0; kind_add = 0; kind_log = 0;
        tag = "R11"; dest = -1; bin = 0; res = '0;
        m_pc = m_pc + 16'd1;
        if (w[15:12] inside {4'b1110, 4'b0101, 4'b0100, 4'b0111, 4'b0110}) begin
            imm = 1; d = 16 + int'(w[7:4]); b = int'({w[11:8], w[3:0]});
        end else begin
            d = int'({w[8], w[7:4]}); s = int'({w[9], w[3:0]}); b = int'(m_reg[s]);
        end
        a = int'(m_reg[d]);
        if (imm) begin
            case (w[15:12])
                4'b1110: begin wr = 1; res = 8'(b); tag = "R9"; end
                4'b0101: begin wr = 1; upd = 1; kind_sub = 1; bin = 0; tag = "R5"; end
                4'b0100: begin wr = 1; upd = 1; kind_sub = 1; bin = int'(m_flags[0]); tag = "R6"; end
                4'b0111: begin wr = 1; upd = 1; kind_log = 1; res = 8'(a & b); tag = "R8"; end
                default: begin wr = 1; upd = 1; kind_log = 1; res = 8'(a | b); tag = "R8"; end
            endcase
        end else begin
            case (w[15:10])
                6'b000011: begin wr = 1; upd = 1; kind_add = 1; bin = 0; tag = "R4"; end
                6'b000111: begin wr = 1; upd = 1; kind_add = 1; bin = int'(m_flags[0]); tag = "R4"; end
                6'b000110: begin wr = 1; upd = 1; kind_sub = 1; bin = 0; tag = "R5"; end
                6'b000010: begin wr = 1; upd = 1; kind_sub = 1; bin = int'(m_flags[0]); tag = "R6"; end
                6'b000101: begin upd = 1; kind_sub = 1; bin = 0; tag = "R7"; end
                6'b000001: begin upd = 1; kind_sub = 1; bin = int'(m_flags[0]); tag = "R7"; end
                6'b001000: begin wr = 1; upd = 1; kind_log = 1; res = 8'(a & b); tag = "R8"; end
                6'b001001: begin wr = 1; upd = 1; kind_log = 1; res = 8'(a ^ b); tag = "R8"; end
                6'b001010: begin wr = 1; upd = 1; kind_log = 1; res = 8'(a | b); tag = "R8"; end
                6'b001011: begin wr = 1; res = 8'(b); tag = "R9"; end
                default: ;
            endcase
        end
        sa = (a > 127) ? a - 256 : a;
        sb = (b > 127) ? b - 256 : b;
        nf = m_flags;
        if (kind_add) begin
            r = a + b + bin; res = 8'(r); sr = sa + sb + bin;
            nf[0] = (r > 255); nf[3] = (sr > 127 || sr < -128);
        end else if (kind_sub) begin
            r = a - b - bin; res = 8'(r); sr = sa - sb - bin;
            nf[0] = ((b + bin) > a); nf[3] = (sr > 127 || sr < -128);
        end else if (kind_log) begin
            nf[3] = 1'b0;
        end
        nf[1] = (res == 8'h00);
        nf[2] = res[7];
        if (upd) m_flags = nf;
        if (wr) begin m_reg[d] = res; dest = d; end
    endtask

    task automatic peek(input int idx, output logic [7:0] v);
        peek_idx = 5'(idx);
        #1;
        v = peek_data;
    endtask

    task automatic sweep(input string tag);
        logic [7:0] v;
        for (int i = 0; i < 32; i++) begin
            peek(i, v);
            chk(v === m_reg[i], tag, int'(v), int'(m_reg[i]));
        end
    endtask

    // Run one word and compare PC, status and the destination.
    task automatic step(input logic [15:0] w);
        string tag;
        int dest;
        logic [7:0] v;
        @(negedge clk);
        instr_word = w;
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        model_exec(w, tag, dest);
        chk(pc === m_pc, "R11", int'(pc), int'(m_pc));
        chk(status === m_flags, {tag, "/R10"}, int'(status), int'(m_flags));
        if (dest >= 0) begin
            peek(dest, v);
            chk(v === m_reg[dest], tag, int'(v), int'(m_reg[dest]));
        end
    endtask

    function automatic logic [15:0] rand_word();
        logic [5:0] rr_ops [10] = '{6'b000011, 6'b000111, 6'b000110, 6'b000010,
            6'b000101, 6'b000001, 6'b001000, 6'b001001, 6'b001010, 6'b001011};
        logic [3:0] rk_ops [5] = '{4'b1110, 4'b0101, 4'b0100, 4'b0111, 4'b0110};
        int sel = int'($urandom_range(0, 19));
        if (sel < 10)
            return enc_rr(rr_ops[sel], int'($urandom_range(0, 31)), int'($urandom_range(0, 31)));
        else if (sel < 17)
            return enc_rk(rk_ops[sel % 5], int'($urandom_range(16, 31)), 8'($urandom));
        else if (sel == 17)
            return 16'h0000;
        else
            return {4'b1111, 12'($urandom)};
    endfunction

    initial begin
        logic [7:0] v;
        logic [15:0] pc_hold;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) m_reg[i] = '0;
        m_flags = '0;
        m_pc = '0;
        repeat (3) @(negedge clk);
        // dirty the state, then reset again to test R1
        rst_n = 1'b1;
        step(enc_rk(4'b1110, 20, 8'h5A));
        step(enc_rk(4'b0101, 20, 8'h7F));
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 32; i++) m_reg[i] = '0;
        m_flags = '0; m_pc = '0;
        chk(pc === 16'h0, "R1", int'(pc), 0);
        chk(status === 4'h0, "R1", int'(status), 0);
        sweep("R1");

        // R5/R6/R10: chained subtract with borrow
        step(enc_rk(4'b1110, 30, 8'h0F));
        step(enc_rk(4'b0101, 30, 8'h10));
        chk(status === 4'b0101, "R5", int'(status), 5);
        step(enc_rk(4'b0100, 30, 8'h01));
        peek(30, v);
        chk(v === 8'hFD, "R6", int'(v), 8'hFD);
        chk(status === 4'b0100, "R6", int'(status), 4);

        // R8: bitwise chain
        step(enc_rk(4'b1110, 30, 8'h3C));
        step(enc_rk(4'b1110, 31, 8'h0F));
        step(enc_rr(6'b001000, 30, 31));
        peek(30, v); chk(v === 8'h0C, "R8", int'(v), 8'h0C);
        step(enc_rk(4'b0111, 30, 8'h08));
        step(enc_rk(4'b0110, 20, 8'hAA));
        peek(20, v); chk(v === 8'hAA, "R8", int'(v), 8'hAA);
        step(enc_rr(6'b001001, 30, 20));
        peek(30, v); chk(v === 8'hA2, "R8", int'(v), 8'hA2);

        // R2: high-bit register fields in both positions
        step(enc_rr(6'b001011, 1, 30));
        step(enc_rr(6'b001011, 17, 1));
        sweep("R2");
        // R3: constant split across nibbles, destination 16
        step(enc_rk(4'b1110, 16, 8'hC3));
        sweep("R3");

        // R4: overflow and carry corners
        step(enc_rk(4'b1110, 18, 8'h7F));
        step(enc_rk(4'b1110, 19, 8'h01));
        step(enc_rr(6'b000011, 18, 19));
        chk(status === 4'b1100, "R4", int'(status), 4'hC);
        step(enc_rk(4'b1110, 21, 8'hFF));
        step(enc_rr(6'b000011, 21, 19));
        chk(status === 4'b0011, "R4", int'(status), 3);
        step(enc_rr(6'b000111, 19, 19));
        peek(19, v); chk(v === 8'h03, "R4", int'(v), 3);

        // R7: compare leaves the file intact
        step(enc_rr(6'b000101, 19, 18));
        step(enc_rr(6'b000001, 18, 19));
        sweep("R7");

        // R11: unknown opcode, nop, idle cycles
        step(16'hF123);
        step(16'h0000);
        sweep("R11");
        pc_hold = pc;
        repeat (4) @(negedge clk);
        chk(pc === pc_hold, "R11", int'(pc), int'(pc_hold));
        chk(status === m_flags, "R11", int'(status), int'(m_flags));

        // random mix
        for (int n = 0; n < 600; n++) begin
            step(rand_word());
            if (n % 100 == 99) sweep("R2");
        end
        sweep("R3");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule